// File: doc/BRIEF.md
# Structured-Sparse (2-of-4) Multiply-Accumulate Lane

This block computes an unsigned dot product over weights pruned to a fixed pattern. In each group of four weights at most two are nonzero. Each cycle it accepts one group of four dense 8-bit activations and two kept weights, each tagged with a 2-bit position inside the group. The position tags steer two multiplexers that pick the matching activations. Both products are added into a 20-bit accumulator in the same cycle. A group of four dense positions therefore costs two multipliers and one cycle, which doubles throughput over a dense lane of the same multiplier count.

The lane takes weights in one of two forms, chosen by `dense_sel`:
- **Compressed form:** two values and two ascending position tags, supplied directly.
- **Dense form:** all four weights. A built-in compressor checks the pattern and derives the two kept entries itself.

A group that breaks the pattern is flagged and dropped from the sum. A group breaks the pattern if it has more than two nonzeros in dense form, or if its tags are not strictly ascending in compressed form.

Control is a three-state machine:
- **IDLE:** no dot product is running. Transition IDLE→RUN on `start` with a nonzero count. Transition IDLE→FINISH on `start` with a count of zero.
- **RUN:** groups are accepted. Transition RUN→FINISH when the last programmed group is accepted. Transition RUN→RUN on `start`, which restarts the dot product.
- **FINISH:** the one-cycle `done` state. Transition FINISH→IDLE with no `start`. Transition FINISH→RUN or FINISH→FINISH on `start`, by the same count rule as in IDLE.

The `start` input clears the accumulator and loads the group count.

Top module: `sp24_mac_lane`

## Requirements
- R1: After reset, `acc_out` is 0 and `busy`, `done` and `grp_err` are 0.
- R2: The cycle after `start` is sampled high, `acc_out` is 0 and `group_count` is loaded. `start` has priority over a group presented in the same cycle.
- R3: In RUN with `dense_sel`=0 and `grp_valid`=1, a valid group adds the sum of two products to the accumulator. Slot k's product is `w_val[k*8+:8]` times the activation at position `w_idx[k*2+:2]`. Activation p is `act[p*8+:8]`. Everything is unsigned.
- R4: In compressed form, a group whose slot-1 tag is not greater than its slot-0 tag is rejected. `grp_err` is 1 in the following cycle, the accumulator is unchanged, and the group does not count toward `group_count`.
- R5: In dense form, a group with at most two nonzero weights adds exactly the full four-term dot product of `w_dense` (weight p at bits [p*8+:8]) with `act`. Internally, missing entries are filled with zero-valued weights at the lowest unused positions, so the tags stay ascending.
- R6: In dense form, a group with three or four nonzero weights is rejected in the same way as in R4.
- R7: `done` is high for exactly one cycle, the cycle after the `group_count`-th accepted group. During that cycle `busy` is 0.
- R8: `grp_valid` outside RUN has no effect on `acc_out` and does not raise `grp_err`.
- R9: The accumulator wraps modulo 2^20.
- R10: `start` during RUN abandons the current sum and restarts with the new count.
- R11: `start` with `group_count`=0 gives `done`=1 in the next cycle with `acc_out`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Clear accumulator, load count, begin |
| group_count | input | 16 | Number of groups to accept |
| dense_sel | input | 1 | 1: dense weights through the compressor, 0: compressed weights |
| grp_valid | input | 1 | A group is presented this cycle |
| w_dense | input | 32 | Four dense weights, position p at [p*8+:8] |
| w_val | input | 16 | Two kept weights, slot k at [k*8+:8] |
| w_idx | input | 4 | Two position tags, slot k at [k*2+:2] |
| act | input | 32 | Four activations, position p at [p*8+:8] |
| acc_out | output | 20 | Accumulator |
| busy | output | 1 | In RUN |
| done | output | 1 | One-cycle completion strobe |
| grp_err | output | 1 | Previous cycle's group was rejected |

## Verification
The hardest situation to reach is a rejected group in the middle of a multi-group dot product. A rejection must leave both the partial sum and the remaining count intact, so that `done` arrives only after the programmed number of good groups. The stimulus starts a three-group run and inserts a compressed group with equal tags between good groups. It then checks that `done` stays low until the third good group has been accepted. The wrap is reached by nine back-to-back full-scale groups. The pad rule is reached through dense groups with zero, one and two nonzeros at the edge positions.

// File: rtl/sp24_pkg.sv
package sp24_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RUN    = 2'd1,
        ST_FINISH = 2'd2
    } sp24_state_e;

endpackage

// File: rtl/sp24_compress.sv
// Turns a dense group into KEEP (value, position) slots in ascending order.
// Nonzeros are kept; missing slots take zero weights at the lowest free positions.
module sp24_compress #(
    parameter int DW   = 8,
    parameter int GRP  = 4,
    parameter int KEEP = 2,
    localparam int IW  = $clog2(GRP)
) (
    input  logic [GRP*DW-1:0]  w_dense,
    output logic [KEEP*DW-1:0] c_val,
    output logic [KEEP*IW-1:0] c_idx,
    output logic               too_dense
);

    int nnz;
    int pad_need;
    int zero_used;
    int slot;

    always_comb begin
        nnz = 0;
        for (int p = 0; p < GRP; p++) begin
            if (w_dense[p*DW +: DW] != '0) nnz++;
        end
        pad_need  = (nnz < KEEP) ? (KEEP - nnz) : 0;
        zero_used = 0;
        slot      = 0;
        c_val     = '0;
        c_idx     = '0;
        for (int p = 0; p < GRP; p++) begin
            logic nz;
            logic take;
            nz   = (w_dense[p*DW +: DW] != '0);
            take = nz || (zero_used < pad_need);
            if (!nz && take) zero_used++;
            if (take && (slot < KEEP)) begin
                c_val[slot*DW +: DW] = w_dense[p*DW +: DW];
                c_idx[slot*IW +: IW] = IW'(p);
                slot++;
            end
        end
        too_dense = (nnz > KEEP);
    end

endmodule

// File: rtl/sp24_pick_mul.sv
// One kept weight: select the activation named by its position tag and multiply.
module sp24_pick_mul #(
    parameter int DW  = 8,
    parameter int GRP = 4,
    localparam int IW = $clog2(GRP)
) (
    input  logic [GRP*DW-1:0] act,
    input  logic [DW-1:0]     wval,
    input  logic [IW-1:0]     widx,
    output logic [2*DW-1:0]   prod
);

    logic [DW-1:0] a_sel;

    always_comb begin
        a_sel = act[widx*DW +: DW];
        prod  = wval * a_sel;
    end

endmodule

// File: rtl/sp24_mac_lane.sv
module sp24_mac_lane
    import sp24_pkg::*;
#(
    parameter int DW    = 8,
    parameter int AW    = 20,
    parameter int GRP   = 4,
    parameter int KEEP  = 2,
    parameter int CNT_W = 16,
    localparam int IW   = $clog2(GRP)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CNT_W-1:0]   group_count,
    input  logic               dense_sel,
    input  logic               grp_valid,
    input  logic [GRP*DW-1:0]  w_dense,
    input  logic [KEEP*DW-1:0] w_val,
    input  logic [KEEP*IW-1:0] w_idx,
    input  logic [GRP*DW-1:0]  act,
    output logic [AW-1:0]      acc_out,
    output logic               busy,
    output logic               done,
    output logic               grp_err
);

    sp24_state_e state, nxt;

    logic [KEEP*DW-1:0] c_val, eff_val;
    logic [KEEP*IW-1:0] c_idx, eff_idx;
    logic               c_bad, order_bad, grp_bad;
    logic [2*DW-1:0]    prod [KEEP];
    logic [AW-1:0]      grp_sum;
    logic [AW-1:0]      acc_q;
    logic [CNT_W-1:0]   remain;
    logic               err_q;
    logic               accept, reject;

    // Dense path: compressor and pattern check
    sp24_compress #(.DW(DW), .GRP(GRP), .KEEP(KEEP)) i_comp (
        .w_dense  (w_dense),
        .c_val    (c_val),
        .c_idx    (c_idx),
        .too_dense(c_bad)
    );

    // Compressed path: tags must be strictly ascending
    always_comb begin
        order_bad = 1'b0;
        for (int k = 1; k < KEEP; k++) begin
            if (w_idx[k*IW +: IW] <= w_idx[(k-1)*IW +: IW]) order_bad = 1'b1;
        end
    end

    assign eff_val = dense_sel ? c_val : w_val;
    assign eff_idx = dense_sel ? c_idx : w_idx;
    assign grp_bad = dense_sel ? c_bad : order_bad;

    generate
        for (genvar k = 0; k < KEEP; k++) begin : g_slot
            sp24_pick_mul #(.DW(DW), .GRP(GRP)) i_pm (
                .act (act),
                .wval(eff_val[k*DW +: DW]),
                .widx(eff_idx[k*IW +: IW]),
                .prod(prod[k])
            );
        end
    endgenerate

    always_comb begin
        grp_sum = '0;
        for (int k = 0; k < KEEP; k++) grp_sum = grp_sum + AW'(prod[k]);
    end

    assign accept = (state == ST_RUN) && grp_valid && !grp_bad && !start;
    assign reject = (state == ST_RUN) && grp_valid &&  grp_bad && !start;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start) nxt = (group_count == '0) ? ST_FINISH : ST_RUN;
            end
            ST_RUN: begin
                if (start)                          nxt = (group_count == '0) ? ST_FINISH : ST_RUN;
                else if (accept && remain == CNT_W'(1)) nxt = ST_FINISH;
            end
            ST_FINISH: begin
                if (start) nxt = (group_count == '0) ? ST_FINISH : ST_RUN;
                else       nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Accumulator, group counter, reject flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            remain <= '0;
            err_q  <= 1'b0;
        end else begin
            err_q <= reject;
            if (start) begin
                acc_q  <= '0;
                remain <= group_count;
            end else if (accept) begin
                acc_q  <= acc_q + grp_sum;
                remain <= remain - CNT_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        acc_out = acc_q;
        busy    = (state == ST_RUN);
        done    = (state == ST_FINISH);
        grp_err = err_q;
    end

    a_r2_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (acc_out == '0));

    a_r4_reject_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && grp_valid && grp_bad && !start) |=> ($stable(acc_out) && grp_err));

    a_r5_comp_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (dense_sel && !c_bad) |-> (c_idx[IW-1:0] < c_idx[2*IW-1:IW]));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

    a_r7_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (remain != '0));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> ($stable(acc_out) && !grp_err));

endmodule

// File: tb/test_sp24_mac_lane.sv
module test_sp24_mac_lane;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] group_count = '0;
    logic        dense_sel = 1'b0;
    logic        grp_valid = 1'b0;
    logic [31:0] w_dense = '0;
    logic [15:0] w_val = '0;
    logic [3:0]  w_idx = '0;
    logic [31:0] act = '0;
    logic [19:0] acc_out;
    logic        busy, done, grp_err;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    sp24_mac_lane i_sp24_mac_lane (
        .clk(clk), .rst_n(rst_n), .start(start), .group_count(group_count),
        .dense_sel(dense_sel), .grp_valid(grp_valid), .w_dense(w_dense),
        .w_val(w_val), .w_idx(w_idx), .act(act), .acc_out(acc_out),
        .busy(busy), .done(done), .grp_err(grp_err)
    );

    // {mode, w_dense, val0, val1, idx0, idx1, act, expected sum, expected reject}
    localparam int NV = 13;
    localparam logic [105:0] VEC [NV] = '{
        {1'b1, 32'h00000503, 8'd0,   8'd0,   2'd0, 2'd0, 32'h04030201, 20'd13,     1'b0},
        {1'b1, 32'h07000002, 8'd0,   8'd0,   2'd0, 2'd0, 32'h04030201, 20'd30,     1'b0},
        {1'b1, 32'h00090000, 8'd0,   8'd0,   2'd0, 2'd0, 32'h04030201, 20'd27,     1'b0},
        {1'b1, 32'h00000000, 8'd0,   8'd0,   2'd0, 2'd0, 32'h04030201, 20'd0,      1'b0},
        {1'b1, 32'h00010101, 8'd0,   8'd0,   2'd0, 2'd0, 32'h04030201, 20'd0,      1'b1},
        {1'b1, 32'h01010101, 8'd0,   8'd0,   2'd0, 2'd0, 32'h04030201, 20'd0,      1'b1},
        {1'b1, 32'h00000006, 8'd0,   8'd0,   2'd0, 2'd0, 32'h04030201, 20'd6,      1'b0},
        {1'b0, 32'h00000000, 8'd10,  8'd20,  2'd1, 2'd3, 32'h04030201, 20'd100,    1'b0},
        {1'b0, 32'h00000000, 8'd255, 8'd255, 2'd0, 2'd1, 32'h04030201, 20'd765,    1'b0},
        {1'b0, 32'h00000000, 8'd5,   8'd5,   2'd2, 2'd2, 32'h04030201, 20'd0,      1'b1},
        {1'b0, 32'h00000000, 8'd5,   8'd5,   2'd3, 2'd0, 32'h04030201, 20'd0,      1'b1},
        {1'b1, 32'hFF00FF00, 8'd0,   8'd0,   2'd0, 2'd0, 32'hFFFFFFFF, 20'd130050, 1'b0},
        {1'b0, 32'h00000000, 8'd255, 8'd255, 2'd2, 2'd3, 32'hFFFFFFFF, 20'd130050, 1'b0}
    };

    task automatic chk(input bit ok, input string tag, input int actual, input int expected);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, actual, expected);
        end
    endtask

    task automatic do_start(input int n);
        start = 1'b1;
        group_count = 16'(n);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic send(input logic [105:0] v);
        dense_sel = v[105];
        w_dense   = v[104:73];
        w_val     = {v[64:57], v[72:65]};
        w_idx     = {v[54:53], v[56:55]};
        act       = v[52:21];
        grp_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        grp_valid = 1'b0;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk(acc_out == 0, "R1 acc", int'(acc_out), 0);
        chk(!busy && !done && !grp_err, "R1 flags", int'({busy, done, grp_err}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: one group per dot product
        for (int i = 0; i < NV; i++) begin
            logic [105:0] v;
            v = VEC[i];
            do_start(1);
            chk(acc_out == 0 && busy, "R2 clear", int'(acc_out), 0);
            send(v);
            if (v[0]) begin
                chk(grp_err, v[105] ? "R6 reject flag" : "R4 reject flag", int'(grp_err), 1);
                chk(acc_out == 0, v[105] ? "R6 acc held" : "R4 acc held", int'(acc_out), 0);
                chk(!done, "R4/R6 not counted", int'(done), 0);
            end else begin
                chk(acc_out == v[20:1], v[105] ? "R5 dense sum" : "R3 sparse sum",
                    int'(acc_out), int'(v[20:1]));
                chk(done && !busy, "R7 done", int'(done), 1);
                chk(!grp_err, "R3 no reject", int'(grp_err), 0);
            end
        end

        // R7/R4: rejection inside a three-group run
        do_start(3);
        send(VEC[7]);
        chk(acc_out == 100 && !done && busy, "R7 first of three", int'(acc_out), 100);
        send(VEC[9]);
        chk(grp_err && acc_out == 100 && !done, "R4 mid-run reject", int'(acc_out), 100);
        send(VEC[0]);
        chk(acc_out == 113 && !done, "R7 second of three", int'(acc_out), 113);
        send(VEC[1]);
        chk(acc_out == 143 && done, "R7 third of three", int'(acc_out), 143);
        @(posedge clk);
        @(negedge clk);
        chk(!done && !busy, "R7 done one cycle", int'(done), 0);

        // R8: group while idle
        send(VEC[7]);
        chk(acc_out == 143 && !grp_err, "R8 idle ignored", int'(acc_out), 143);
        send(VEC[9]);
        chk(!grp_err, "R8 idle no reject", int'(grp_err), 0);

        // R11: zero count
        do_start(0);
        chk(done && acc_out == 0 && !busy, "R11 zero count", int'(done), 1);
        @(posedge clk);
        @(negedge clk);
        chk(!done, "R11 done drops", int'(done), 0);

        // R9: wrap after nine full-scale groups
        do_start(9);
        for (int g = 0; g < 9; g++) send(VEC[12]);
        chk(acc_out == 20'd121874 && done, "R9 wrap", int'(acc_out), 121874);

        // R10: restart mid-run
        do_start(2);
        send(VEC[7]);
        chk(acc_out == 100 && busy, "R10 partial", int'(acc_out), 100);
        do_start(1);
        chk(acc_out == 0 && busy, "R10 restart clears", int'(acc_out), 0);
        send(VEC[6]);
        chk(acc_out == 6 && done, "R10 new count", int'(acc_out), 6);

        // R2: start wins over a group in the same cycle
        dense_sel = 1'b0; w_val = {8'd20, 8'd10}; w_idx = {2'd3, 2'd1};
        act = 32'h04030201; grp_valid = 1'b1;
        do_start(1);
        grp_valid = 1'b0;
        chk(acc_out == 0 && busy, "R2 start priority", int'(acc_out), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule